// File: doc/BRIEF.md
# Modulo 2^n+1 Sequential Multiplier

This block multiplies two residues modulo 2^n+1 and returns X·Y mod (2^n+1). It is meant for arithmetic over the Fermat-style modulus used by block ciphers and residue-number datapaths. The multiplier walks the bits of Y from the most significant end, one bit per clock. In each step the running partial product is doubled modulo 2^n+1, and then X or zero is added modulo 2^n+1. Both operations go through the same modulo adder structure.

That adder sums its inputs in plain binary and keeps only the low n bits. Each carry out of bit n-1 stands for 2^n, which is congruent to −1. The kept n bits therefore differ from the residue by the number of carries, either one or two. A small correction stage takes that carry count back off and adds the modulus once when the difference goes negative. Every partial product stays in [0, 2^n], so the result needs no further correction pass. Operands are n+1 bits wide. The value 2^n is the residue −1, and larger raw values are folded into range when they are captured.

A caller presents the operands with a one-cycle start while the block is idle. It then waits for the one-cycle done pulse, after which the product register holds the answer until the next completion.

Top module: `resmul_top`

## Requirements
- R1: When an operation completes, product equals (X·Y) mod (2^n+1) for operands X and Y in [0, 2^n].
- R2: An operand equal to 2^n acts as the residue −1. For example, 2^n·2^n gives 1, and 2^n·k gives 2^n+1−k for 1 ≤ k ≤ 2^n.
- R3: If either operand is zero, the product is zero.
- R4: Raw operand values from 2^n+1 to 2^(n+1)−1 are accepted and treated as their integer value reduced modulo 2^n+1.
- R5: A start seen while idle raises busy on the next clock edge. Busy stays high for exactly n+1 cycles. Done is high for exactly one cycle, on the edge where busy falls, and the product register is updated on that same edge.
- R6: A start asserted while busy is ignored. The running operation keeps its operands and its timing.
- R7: The product register changes only on the edge that raises done. It holds its value while inputs change without a start.
- R8: After reset, busy is 0, done is 0 and product is 0.
- R9: The product is always within [0, 2^n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| xIn | input | WIDTH+1 | Multiplicand, captured at start |
| yIn | input | WIDTH+1 | Multiplier, captured at start, consumed MSB first |
| busy | output | 1 | High while the step sequence runs |
| done | output | 1 | One-cycle completion pulse |
| product | output | WIDTH+1 | Registered result residue |

## Verification
The hardest path to reach is the correction that subtracts two carries and then wraps through the modulus. It only occurs when both adder inputs sit at or near 2^n. Random operands almost never land there, so the directed table includes products that involve 2^n and 2^n−1. A second multiplier at n=16 repeats this. A start pulse is also injected in the middle of an operation, with different operands, to show that it leaves the result and the latency unchanged.

// File: rtl/resmul_pkg.sv
package resmul_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture operands, clear partial product
    logic step;    // double and conditionally accumulate
    logic finish;  // copy the stepped value into the product register
  } resmulCtrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } resmulState_e;

endpackage

// File: rtl/resmul_add.sv
// Modulo 2^W+1 adder for inputs in [0, 2^(W+1)-1] whose sum fits W+2 bits.
// The binary sum keeps only its low W bits; each dropped carry stands for
// 2^W, congruent to -1, so the kept value sits hi above the residue.
// The correction stage removes hi (one or two) and wraps through the modulus.
module resmul_add #(
  parameter int W = 8
) (
  input  logic [W:0] a,
  input  logic [W:0] b,
  output logic [W:0] res
);

  logic [W+1:0] rawSum;
  logic [W-1:0] lowPart;
  logic [1:0]   carryCnt;
  logic [W:0]   lowExt;
  logic [W:0]   carryExt;

  always_comb begin
    rawSum   = {1'b0, a} + {1'b0, b};
    lowPart  = rawSum[W-1:0];
    carryCnt = rawSum[W+1:W];
    lowExt   = {1'b0, lowPart};
    carryExt = {{(W-1){1'b0}}, carryCnt};
    if (lowExt >= carryExt) begin
      res = lowExt - carryExt;
    end else begin
      // lowPart + 2^W + 1 - carryCnt, at most 2^W, fits W+1 bits
      res = {1'b1, lowPart} + {{W{1'b0}}, 1'b1} - carryExt;
    end
  end

endmodule

// File: rtl/resmul_ctrl.sv
module resmul_ctrl
  import resmul_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDXW = $clog2(WIDTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  output resmulCtrl_t     ctrl,
  output logic [IDXW-1:0] bitIdx,
  output logic            busy,
  output logic            done
);

  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(WIDTH);

  resmulState_e    state;
  logic [IDXW-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            stepCnt <= TOP_IDX;
          end
        end
        ST_RUN: begin
          if (stepCnt == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            stepCnt <= stepCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load   = (state == ST_IDLE) && start;
    ctrl.step   = (state == ST_RUN);
    ctrl.finish = (state == ST_RUN) && (stepCnt == '0);
    bitIdx      = stepCnt;
    busy        = (state == ST_RUN);
  end

endmodule

// File: rtl/resmul_datapath.sv
module resmul_datapath
  import resmul_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDXW = $clog2(WIDTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  resmulCtrl_t     ctrl,
  input  logic [IDXW-1:0] bitIdx,
  input  logic [WIDTH:0]  xIn,
  input  logic [WIDTH:0]  yIn,
  output logic [WIDTH:0]  product
);

  logic [WIDTH:0] xReg;
  logic [WIDTH:0] yReg;
  logic [WIDTH:0] partReg;
  logic [WIDTH:0] xFolded;
  logic [WIDTH:0] doubled;
  logic [WIDTH:0] addend;
  logic [WIDTH:0] stepped;

  // fold a raw operand above 2^WIDTH back into the residue range
  resmul_add #(.W(WIDTH)) foldX_i (
    .a  (xIn),
    .b  ('0),
    .res(xFolded)
  );

  // modular doubling: P + P through the same adder structure
  resmul_add #(.W(WIDTH)) dbl_i (
    .a  (partReg),
    .b  (partReg),
    .res(doubled)
  );

  always_comb begin
    addend = yReg[bitIdx] ? xReg : '0;
  end

  resmul_add #(.W(WIDTH)) acc_i (
    .a  (doubled),
    .b  (addend),
    .res(stepped)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg    <= '0;
      yReg    <= '0;
      partReg <= '0;
      product <= '0;
    end else begin
      if (ctrl.load) begin
        xReg    <= xFolded;
        yReg    <= yIn;
        partReg <= '0;
      end else if (ctrl.step) begin
        partReg <= stepped;
      end
      if (ctrl.finish) begin
        product <= stepped;
      end
    end
  end

endmodule

// File: rtl/resmul_top.sv
module resmul_top
  import resmul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [WIDTH:0] xIn,
  input  logic [WIDTH:0] yIn,
  output logic           busy,
  output logic           done,
  output logic [WIDTH:0] product
);

  localparam int IDXW = $clog2(WIDTH + 1);

  resmulCtrl_t     ctrlBus;
  logic [IDXW-1:0] bitIdx;

  resmul_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrlBus),
    .bitIdx(bitIdx),
    .busy  (busy),
    .done  (done)
  );

  resmul_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrlBus),
    .bitIdx (bitIdx),
    .xIn    (xIn),
    .yIn    (yIn),
    .product(product)
  );

endmodule

// File: rtl/resmul_checker.sv
module resmul_checker #(
  parameter int W = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [W:0] product
);

  localparam int CW = $clog2(W + 2) + 1;
  localparam logic [W:0] MAXRES = {1'b1, {W{1'b0}}};

  logic          pastValid;
  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pastValid <= 1'b0;
      busyCnt   <= '0;
    end else begin
      pastValid <= 1'b1;
      busyCnt   <= busy ? busyCnt + 1'b1 : '0;
    end
  end

  // R5: done lasts one cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: done arrives after exactly W+1 busy cycles
  a_r5_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == CW'(W + 1)));

  // R5: done coincides with busy falling
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5: busy only rises after a start
  a_r5_launch: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(busy)) |-> $past(start));

  // R6: a run is not cut short, whatever start does
  a_r6_run_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (busyCnt < CW'(W))) |=> busy);

  // R7: product only moves with done
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !done) |-> $stable(product));

  // R9: result stays a valid residue
  a_r9_range: assert property (@(posedge clk) disable iff (!rstN)
    product <= MAXRES);

endmodule

bind resmul_top resmul_checker #(.W(WIDTH)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .product(product)
);

// File: tb/resmul_top_tb_top.sv
`timescale 1ns/1ps
module resmul_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        start8 = 1'b0, start16 = 1'b0;
  logic [8:0]  x8 = '0, y8 = '0, p8;
  logic [16:0] x16 = '0, y16 = '0, p16;
  logic        busy8, done8, busy16, done16;

  int nChecks = 0;
  int nFails  = 0;

  resmul_top #(.WIDTH(8)) dut_i (
    .clk(clk), .rstN(rstN), .start(start8), .xIn(x8), .yIn(y8),
    .busy(busy8), .done(done8), .product(p8)
  );

  resmul_top #(.WIDTH(16)) dut16_i (
    .clk(clk), .rstN(rstN), .start(start16), .xIn(x16), .yIn(y16),
    .busy(busy16), .done(done16), .product(p16)
  );

  // x, y, expected product for n = 8 (modulus 257)
  localparam int VEC [12][3] = '{
    '{3, 5, 15},      '{0, 200, 0},     '{256, 256, 1},   '{256, 1, 256},
    '{2, 128, 256},   '{16, 16, 256},   '{255, 255, 4},   '{100, 200, 211},
    '{256, 7, 250},   '{511, 3, 248},   '{300, 300, 50},  '{1, 0, 0}
  };

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model(input longint x, input longint y, input int n);
    longint m = (longint'(1) << n) + 1;
    return ((x % m) * (y % m)) % m;
  endfunction

  // runs one operation; lat counts negedges with busy high before done
  task automatic runOp(input bit wide, input longint x, input longint y,
                       output longint prod, output int lat);
    @(negedge clk);
    if (wide) begin x16 = 17'(x); y16 = 17'(y); start16 = 1'b1; end
    else      begin x8  = 9'(x);  y8  = 9'(y);  start8  = 1'b1; end
    @(negedge clk);
    start8 = 1'b0; start16 = 1'b0;
    lat = 0;
    for (int k = 0; k < 100; k++) begin
      if (wide ? done16 : done8) break;
      if (wide ? busy16 : busy8) lat++;
      @(negedge clk);
    end
    prod = wide ? longint'(p16) : longint'(p8);
  endtask

  function automatic string tagOf(input longint x, input longint y, input int n);
    longint top = longint'(1) << n;
    if (x == 0 || y == 0) return "R3";
    if (x > top || y > top) return "R4";
    if (x == top || y == top) return "R2";
    return "R1";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    longint pr, hold;
    int lat;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check("R8 busy8", busy8, 0);
    check("R8 done8", done8, 0);
    check("R8 product8", p8, 0);
    check("R8 product16", p16, 0);
    rstN = 1'b1;

    // table walk, n = 8
    foreach (VEC[i]) begin
      runOp(1'b0, VEC[i][0], VEC[i][1], pr, lat);
      check(tagOf(VEC[i][0], VEC[i][1], 8), pr, VEC[i][2]);
      check("R9 range8", (pr <= 256) ? 1 : 0, 1);
    end

    // R5: latency of n+1 busy cycles for both widths
    runOp(1'b0, 77, 91, pr, lat);
    check("R5 latency8", lat, 9);
    runOp(1'b1, 1234, 5678, pr, lat);
    check("R5 latency16", lat, 17);
    check("R1 product16", pr, model(1234, 5678, 16));

    // corner residues at n = 16
    runOp(1'b1, 65536, 65536, pr, lat);
    check("R2 minus1 squared 16", pr, 1);
    runOp(1'b1, 65536, 65535, pr, lat);
    check("R2 minus1 times minus2 16", pr, 2);
    runOp(1'b1, 65535, 65535, pr, lat);
    check("R1 minus2 squared 16", pr, 4);
    runOp(1'b1, 131071, 131071, pr, lat);
    check("R4 raw max 16", pr, model(131071, 131071, 16));
    runOp(1'b1, 0, 65536, pr, lat);
    check("R3 zero 16", pr, 0);

    // R6: start while busy with other operands is ignored
    @(negedge clk);
    x8 = 9'd3; y8 = 9'd5; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    repeat (2) @(negedge clk);
    x8 = 9'd7; y8 = 9'd9; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    lat = 3;
    for (int k = 0; k < 100; k++) begin
      if (done8) break;
      if (busy8) lat++;
      @(negedge clk);
    end
    check("R6 result unchanged", p8, 15);
    check("R6 timing unchanged", lat, 9);
    @(negedge clk);
    check("R6 no relaunch", busy8, 0);

    // R7: product holds while inputs move without start
    hold = p8;
    x8 = 9'd200; y8 = 9'd100;
    repeat (12) @(negedge clk);
    check("R7 hold", p8, hold);

    // random sweep, both widths
    for (int i = 0; i < 60; i++) begin
      longint a = longint'($urandom_range(0, 511));
      longint b = longint'($urandom_range(0, 511));
      runOp(1'b0, a, b, pr, lat);
      check(tagOf(a, b, 8), pr, model(a, b, 8));
    end
    for (int i = 0; i < 60; i++) begin
      longint a = longint'($urandom_range(0, 131071));
      longint b = longint'($urandom_range(0, 131071));
      runOp(1'b1, a, b, pr, lat);
      check(tagOf(a, b, 16), pr, model(a, b, 16));
      check("R9 range16", (pr <= 65536) ? 1 : 0, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule